// File: doc/BRIEF.md
# SDRAM Init and Refresh Sequencer

This block owns the command pins of a single-data-rate SDRAM from the moment reset is released. It first holds the bus quiet for the power-up pause, with clock enable and the data masks driven high. It then closes every bank, loads the mode register with a parameterised word, and runs a fixed number of auto-refresh commands. Only after that does it report the memory as usable.

Once usable, the block counts the average refresh interval and keeps a debt of owed refreshes. It asks the user datapath for a refresh slot and waits for that path to report, through an idle input, that all banks are closed. Each refresh it issues is followed by the refresh recovery time, which it flags as busy. All timing is given in nanoseconds and converted to clock counts by rounding up against the clock period.

Top module: `sdram_init_refresh`

## Requirements
- R1: During reset and for PAUSE_CYC = ceil(T_PAUSE_NS*1000/CLK_PERIOD_PS) cycles after it (20000 at defaults), the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), cke_o is 1, every dqm_o bit is 1 and ready_o is 0.
- R2: The first command other than NOP is precharge-all (0010) with addr_o bit 10 high. It appears exactly PAUSE_CYC clock edges after reset release.
- R3: The mode-register load (0000) follows the precharge by exactly RP_CYC = ceil(T_RP_NS*1000/CLK_PERIOD_PS) cycles (2 at defaults). It carries ba_o = 0 and addr_o = MODE_WORD. The default word has burst-length code 010 (four) in bits 2:0, sequential order (0) in bit 3 and latency code 011 (three) in bits 6:4, giving 0x032.
- R4: INIT_REFS (8) auto-refresh commands (0001) follow. The first comes T_MRD_CYC (2) cycles after the mode load and each later one RFC_CYC = ceil(T_RFC_NS*1000/CLK_PERIOD_PS) (8) cycles after the previous. idle_i has no effect on them.
- R5: ready_o rises exactly RFC_CYC cycles after the last init refresh and then stays high. From that cycle on, dqm_o is 0, cke_o is 1 and the only commands are NOP and auto-refresh.
- R6: Every timing count is the rounded-up quotient of time and clock period. The refresh interval is REFI_CYC = ceil(T_REFI_NS*1000/CLK_PERIOD_PS) (780 at defaults).
- R7: The refresh debt grows by one every REFI_CYC cycles, counted from the cycle ready_o rises. ref_req_o is high exactly when the debt is nonzero.
- R8: After ready, an auto-refresh is issued on an edge if and only if debt is nonzero, idle_i is high at that edge, and at least RFC_CYC+1 cycles have passed since the previous refresh. Each refresh issued lowers the debt by one.
- R9: ref_busy_o is high for RFC_CYC cycles, starting with the cycle that shows a post-ready refresh on the pins, and low otherwise.
- R10: When an interval tick and a refresh grant fall on the same edge, the debt is unchanged.
- R11: The debt saturates at DEBT_MAX (8). After a long idle-low stretch, exactly DEBT_MAX refreshes are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | User path reports all banks closed and the bus free |
| ready_o | output | 1 | Init sequence complete |
| ref_req_o | output | 1 | Refresh debt outstanding |
| ref_busy_o | output | 1 | Refresh recovery in progress |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| dqm_o | output | DQM_W | Data masks |

## Verification
The interval tick that adds to the debt and a refresh grant that removes from it can land on the same clock edge. The bench provokes this by holding idle_i low until one refresh is owed. It then raises idle_i so that it is sampled on the very edge of the next tick. ref_req_o must stay high and a refresh must appear on that edge. A cycle-by-cycle debt model in the bench, built from the tick schedule and the observed grants, judges every such coincidence again during a long random idle_i phase.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_MODE,
    CMD_AREF
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PALL_WAIT,
    ST_MODE_WAIT,
    ST_IREF_WAIT,
    ST_RUN,
    ST_REF_WAIT
  } seq_st_e;

  // round up: cycles = ceil(ns * 1000 / period_ps)
  function automatic int ns_to_cyc(input longint ns, input longint period_ps);
    return int'((ns * 1000 + period_ps - 1) / period_ps);
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W        = 16,
  parameter int INIT_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= W'(INIT_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int REFI_CYC = 780,
  parameter int DEBT_MAX = 8,
  localparam int IV_W    = $clog2(REFI_CYC + 1),
  localparam int DEBT_W  = $clog2(DEBT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              take_i,
  output logic [DEBT_W-1:0] debt_o
);
  localparam logic [IV_W-1:0]   IV_LAST = IV_W'(REFI_CYC - 1);
  localparam logic [DEBT_W-1:0] D_MAX   = DEBT_W'(DEBT_MAX);

  logic [IV_W-1:0]   iv_q;
  logic [DEBT_W-1:0] debt_q;
  logic              tick;

  assign tick = run_i && (iv_q == IV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            iv_q <= '0;
    else if (!run_i || tick) iv_q <= '0;
    else                     iv_q <= iv_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else begin
      unique case ({tick, take_i})
        2'b10:   if (debt_q != D_MAX) debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign debt_o = debt_q;
endmodule

// File: rtl/cmd_encoder.sv
module cmd_encoder
  import sdram_seq_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                BA_W      = 2,
  parameter int                DQM_W     = 2,
  parameter int                PALL_BIT  = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h032
) (
  input  cmd_e              cmd_i,
  input  logic              ready_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o
);
  always_comb begin
    cs_no  = 1'b0;
    ras_no = 1'b1;
    cas_no = 1'b1;
    we_no  = 1'b1;
    addr_o = '0;
    unique case (cmd_i)
      CMD_PALL: begin
        ras_no           = 1'b0;
        we_no            = 1'b0;
        addr_o[PALL_BIT] = 1'b1;
      end
      CMD_MODE: begin
        ras_no = 1'b0;
        cas_no = 1'b0;
        we_no  = 1'b0;
        addr_o = MODE_WORD;
      end
      CMD_AREF: begin
        ras_no = 1'b0;
        cas_no = 1'b0;
      end
      default: ;
    endcase
  end

  assign cke_o = 1'b1;
  assign ba_o  = '0;
  assign dqm_o = ready_i ? '0 : '1;
endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdram_seq_pkg::*;
#(
  parameter int                CLK_PERIOD_PS = 10000,
  parameter int                T_PAUSE_NS    = 200000,
  parameter int                T_RP_NS       = 18,
  parameter int                T_RFC_NS      = 72,
  parameter int                T_REFI_NS     = 7800,
  parameter int                T_MRD_CYC     = 2,
  parameter int                INIT_REFS     = 8,
  parameter int                DEBT_MAX      = 8,
  parameter int                ADDR_W        = 13,
  parameter int                BA_W          = 2,
  parameter int                DQM_W         = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD     = 13'h032
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  output logic              ready_o,
  output logic              ref_req_o,
  output logic              ref_busy_o,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o
);
  localparam int PALL_BIT  = 10;
  localparam int PAUSE_CYC = ns_to_cyc(T_PAUSE_NS, CLK_PERIOD_PS);
  localparam int RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int RFC_CYC   = ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS);
  localparam int REFI_CYC  = ns_to_cyc(T_REFI_NS, CLK_PERIOD_PS);
  localparam int MAX_A     = (PAUSE_CYC > RFC_CYC) ? PAUSE_CYC : RFC_CYC;
  localparam int MAX_B     = (RP_CYC > T_MRD_CYC) ? RP_CYC : T_MRD_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);
  localparam int IR_W      = $clog2(INIT_REFS + 1);
  localparam int DEBT_W    = $clog2(DEBT_MAX + 1);

  localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(RP_CYC - 1);
  localparam logic [TMR_W-1:0] MRD_LD = TMR_W'(T_MRD_CYC - 1);
  localparam logic [TMR_W-1:0] RFC_LD = TMR_W'(RFC_CYC - 1);

  seq_st_e           st_q, st_d;
  cmd_e              cmd_q, cmd_d;
  logic              ready_q;
  logic [IR_W-1:0]   iref_q;
  logic [DEBT_W-1:0] debt;
  logic              tz, load;
  logic [TMR_W-1:0]  load_val;
  logic              issue_pall, issue_mode, issue_iref, issue_ref, go_run;

  seq_timer #(.W(TMR_W), .INIT_VAL(PAUSE_CYC - 1)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .zero_o(tz)
  );

  refresh_debt #(.REFI_CYC(REFI_CYC), .DEBT_MAX(DEBT_MAX)) u_debt (
    .clk_i, .rst_ni, .run_i(ready_q), .take_i(issue_ref), .debt_o(debt)
  );

  cmd_encoder #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W),
    .PALL_BIT(PALL_BIT), .MODE_WORD(MODE_WORD)
  ) u_enc (
    .cmd_i(cmd_q), .ready_i(ready_q), .cke_o, .cs_no, .ras_no, .cas_no,
    .we_no, .ba_o, .addr_o, .dqm_o
  );

  logic iref_done;
  assign iref_done  = (iref_q == IR_W'(INIT_REFS));
  assign issue_pall = (st_q == ST_PAUSE) && tz;
  assign issue_mode = (st_q == ST_PALL_WAIT) && tz;
  assign issue_iref = ((st_q == ST_MODE_WAIT) && tz) ||
                      ((st_q == ST_IREF_WAIT) && tz && !iref_done);
  assign go_run     = (st_q == ST_IREF_WAIT) && tz && iref_done;
  assign issue_ref  = (st_q == ST_RUN) && (debt != '0) && idle_i;

  always_comb begin
    st_d     = st_q;
    cmd_d    = CMD_NOP;
    load     = 1'b0;
    load_val = RFC_LD;
    if (issue_pall) begin
      st_d = ST_PALL_WAIT; cmd_d = CMD_PALL; load = 1'b1; load_val = RP_LD;
    end else if (issue_mode) begin
      st_d = ST_MODE_WAIT; cmd_d = CMD_MODE; load = 1'b1; load_val = MRD_LD;
    end else if (issue_iref) begin
      st_d = ST_IREF_WAIT; cmd_d = CMD_AREF; load = 1'b1;
    end else if (go_run) begin
      st_d = ST_RUN;
    end else if (issue_ref) begin
      st_d = ST_REF_WAIT; cmd_d = CMD_AREF; load = 1'b1;
    end else if ((st_q == ST_REF_WAIT) && tz) begin
      st_d = ST_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PAUSE;
      cmd_q   <= CMD_NOP;
      ready_q <= 1'b0;
      iref_q  <= '0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      if (go_run)     ready_q <= 1'b1;
      if (issue_iref) iref_q  <= iref_q + 1'b1;
    end
  end

  assign ready_o    = ready_q;
  assign ref_req_o  = (debt != '0);
  assign ref_busy_o = (st_q == ST_REF_WAIT);
endmodule

// File: rtl/sdram_init_refresh_chk.sv
module sdram_init_refresh_chk #(
  parameter int RFC_CYC  = 8,
  parameter int ADDR_W   = 13,
  parameter int DQM_W    = 2,
  parameter int PALL_BIT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              idle_i,
  input logic              ready_o,
  input logic              ref_req_o,
  input logic              ref_busy_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DQM_W-1:0]  dqm_o
);
  localparam int GW = $clog2(RFC_CYC + 1);
  logic [3:0] code;
  logic       is_ref, is_pall, is_nop;
  logic [GW-1:0] gap_q;

  assign code    = {cs_no, ras_no, cas_no, we_no};
  assign is_ref  = (code == 4'b0001);
  assign is_pall = (code == 4'b0010);
  assign is_nop  = (code == 4'b0111);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= GW'(RFC_CYC);
    else if (is_ref)                 gap_q <= GW'(1);
    else if (gap_q < GW'(RFC_CYC))   gap_q <= gap_q + 1'b1;
  end

  p_pall_a10_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pall |-> addr_o[PALL_BIT]);
  p_ref_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |-> gap_q >= GW'(RFC_CYC));
  p_ready_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ready_o) |-> ready_o);
  p_ready_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (dqm_o == '0) && is_nop);
  p_req_after_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> ready_o);
  p_ref_needs_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ref && $past(ready_o)) |-> $past(idle_i));
  p_ref_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ref && $past(ready_o)) |-> ref_busy_o);
  p_busy_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_busy_o && $past(ref_busy_o)) |-> is_nop);
endmodule

bind sdram_init_refresh sdram_init_refresh_chk #(
  .RFC_CYC(RFC_CYC), .ADDR_W(ADDR_W), .DQM_W(DQM_W), .PALL_BIT(PALL_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle_i), .ready_o(ready_o),
  .ref_req_o(ref_req_o), .ref_busy_o(ref_busy_o), .cs_no(cs_no),
  .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no), .addr_o(addr_o),
  .dqm_o(dqm_o)
);

// File: tb/sdram_init_refresh_bench.sv
`timescale 1ns/1ps
module sdram_init_refresh_bench;
  localparam int PER_PS = 10000;
  localparam int DMAX   = 8;
  localparam int NREF   = 8;
  localparam int MRD    = 2;

  function automatic int cdiv(input longint ns);
    return int'((ns * 1000 + PER_PS - 1) / PER_PS);
  endfunction
  function automatic int mode_word(input int lat, input int bt, input int bl);
    return (lat << 4) | (bt << 3) | bl;
  endfunction

  localparam int PAUSE = cdiv(200000);
  localparam int RP    = cdiv(18);
  localparam int RFC   = cdiv(72);
  localparam int REFI  = cdiv(7800);

  logic clk_i = 1'b0, rst_ni = 1'b0, idle_i = 1'b0;
  logic ready_o, ref_req_o, ref_busy_o, cke_o, cs_no, ras_no, cas_no, we_no;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;
  logic [1:0]  dqm_o;

  always #5 clk_i = ~clk_i;

  sdram_init_refresh u_sdram_init_refresh (
    .clk_i, .rst_ni, .idle_i, .ready_o, .ref_req_o, .ref_busy_o, .cke_o,
    .cs_no, .ras_no, .cas_no, .we_no, .ba_o, .addr_o, .dqm_o
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      if (n_err < 30) $display("FAIL %s at cycle %0d: actual=%0d expected=%0d",
                               req, cyc, act, exp);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0; else cyc <= cyc + 1;

  // monitor state
  int  pall_c = -1, mode_c = -1, n_init = 0, last_ref = -1, rdy_c = -1;
  int  debt_m = 0, n_run_ref = 0, n_coll = 0;
  bit  seen_rdy = 0;

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      automatic logic [3:0] code = {cs_no, ras_no, cas_no, we_no};
      automatic bit idle_edge = idle_i;
      if (!seen_rdy) begin
        if (cyc < PAUSE) begin
          chk(code == 4'b0111 && cke_o && dqm_o == 2'b11 && !ready_o, "R1",
              code, 4'b0111);
        end
        if (code == 4'b0010) begin
          chk(cyc == PAUSE, "R2 pall time", cyc, PAUSE);
          chk(addr_o[10], "R2 pall a10", addr_o[10], 1);
          pall_c = cyc;
        end else if (code == 4'b0000) begin
          chk(cyc == pall_c + RP, "R3 mode time R6", cyc, pall_c + RP);
          chk(addr_o == 13'(mode_word(3, 0, 2)) && ba_o == 0, "R3 mode word",
              addr_o, mode_word(3, 0, 2));
          mode_c = cyc;
        end else if (code == 4'b0001) begin
          automatic int e = (n_init == 0) ? mode_c + MRD : last_ref + RFC;
          chk(cyc == e, "R4 init ref time", cyc, e);
          n_init++;
          last_ref = cyc;
        end
        if (ready_o) begin
          chk(cyc == last_ref + RFC && n_init == NREF, "R5 ready time", cyc,
              last_ref + RFC);
          rdy_c = cyc;
          seen_rdy = 1;
        end
      end else begin
        automatic bit tick = (cyc > rdy_c) && ((cyc - rdy_c) % REFI == 0);
        automatic bit exp_ref = (debt_m > 0) && idle_edge &&
                                (cyc >= last_ref + RFC + 1);
        automatic bit busy_e;
        chk((code == 4'b0001) == exp_ref, "R8 grant", code == 4'b0001, exp_ref);
        if (tick && exp_ref) n_coll++;
        debt_m = debt_m + int'(tick) - int'(exp_ref);
        if (debt_m > DMAX) debt_m = DMAX;
        if (code == 4'b0001) begin
          last_ref = cyc;
          n_run_ref++;
        end
        chk(ref_req_o == (debt_m != 0), "R7 req/debt R10 R11", ref_req_o,
            debt_m != 0);
        busy_e = (cyc <= last_ref + RFC - 1) && (last_ref > rdy_c);
        chk(ref_busy_o == busy_e, "R9 busy", ref_busy_o, busy_e);
        chk(ready_o && cke_o && dqm_o == 0 && (code == 4'b0111 || code == 4'b0001),
            "R5 run pins", {ready_o, cke_o, dqm_o, code}, {2'b11, 2'b00, 4'b0111});
      end
    end
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk_i);
    #1;
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk_i);
    chk(cke_o && dqm_o == 2'b11 && !ready_o && {cs_no, ras_no, cas_no, we_no} == 4'b0111,
        "R1 reset", {cke_o, dqm_o, ready_o}, 4'b1110);
    chk(!ref_req_o && !ref_busy_o, "R1 reset flags", {ref_req_o, ref_busy_o}, 0);
    #1 rst_ni = 1'b1;
    // idle held low during init: must have no effect (R4)
    while (!seen_rdy) @(negedge clk_i);
    #1;
    chk(n_init == NREF, "R4 init count", n_init, NREF);
    idle_i = 1'b0;
    wait_to(rdy_c + REFI);
    chk(ref_req_o, "R7 first tick R6", ref_req_o, 1);
    idle_i = 1'b1;
    wait_to(rdy_c + 2 * REFI + 5);
    chk(n_run_ref == 2 && !ref_req_o, "R8 immediate grants", n_run_ref, 2);
    // saturation
    idle_i = 1'b0;
    wait_to(rdy_c + 13 * REFI + 5);
    chk(ref_req_o, "R11 pending", ref_req_o, 1);
    begin
      automatic int base = n_run_ref;
      idle_i = 1'b1;
      wait_to(rdy_c + 13 * REFI + 200);
      chk(n_run_ref - base == DMAX, "R11 saturated count", n_run_ref - base, DMAX);
      chk(!ref_req_o, "R11 drained", ref_req_o, 0);
    end
    // tick and grant on the same edge
    idle_i = 1'b0;
    wait_to(rdy_c + 15 * REFI - 1);
    idle_i = 1'b1;
    wait_to(rdy_c + 15 * REFI);
    chk(last_ref == rdy_c + 15 * REFI, "R10 grant on tick", last_ref,
        rdy_c + 15 * REFI);
    chk(ref_req_o, "R10 debt kept", ref_req_o, 1);
    wait_to(rdy_c + 15 * REFI + RFC + 3);
    chk(!ref_req_o && last_ref == rdy_c + 15 * REFI + RFC + 1, "R10 follow-up",
        last_ref, rdy_c + 15 * REFI + RFC + 1);
    // random idle phase
    wait_to(rdy_c + 16 * REFI);
    for (int i = 0; i < 30 * REFI; i++) begin
      if ($urandom_range(0, 63) == 0) idle_i = ~idle_i;
      @(negedge clk_i);
      #1;
    end
    idle_i = 1'b1;
    repeat (DMAX * (RFC + 1) + 10) @(negedge clk_i);
    chk(n_coll >= 1, "R10 coincidence seen", n_coll, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule